// File: doc/BRIEF.md
# Receiver-side multiframe clock phase alignment controller

This block sits in a converter-side high-speed serial receiver and owns the local multiframe clock. A free-running counter wraps once per multiframe period and emits a one-cycle boundary pulse. The phase of that counter is not fixed at reset. The block corrects it in a closed loop, using phase-correction commands that the transmitter sends back.

The loop runs as follows. The block drives its active-low synchronization output low to ask for code group synchronization. It holds that request for at least one full multiframe period, and until the lane reports that code groups are being received. It then releases the request and waits for the decoded configuration frame at index 1 of the initial alignment sequence. From that frame it takes three fields: an adjust-enable bit, a step count and a direction bit. If an adjustment is commanded, the block moves its counter phase by one device-clock cycle per multiframe period, once for each step. An advance skips a counter state and a delay holds the counter for one extra cycle. After the last step it requests synchronization again, so that the transmitter can re-measure. A configuration frame that commands nothing, or a step count of zero, ends the loop with the aligned flag set. If the transmitter still asks for a correction after a set number of loops, the block stops with an error flag instead.

Top module: `lmfc_phase_ctrl`

## Requirements
- R1: The counter period is P = FRAMES_PER_MF*OCTETS_PER_FRAME/OCTETS_PER_CLK cycles. `lmfc_edge_o` is high exactly in the cycles where the counter is 0, and the counter is 0 in the first cycle after reset is released. Between two consecutive pulses there are only P-1, P or P+1 cycles.
- R2: `sync_no` is low (a synchronization request) out of reset and at every new request. Each low phase lasts at least P cycles and continues while `cgs_ok_i` is low.
- R3: The correction fields are taken only from a beat with `cfg_valid_i`=1 and `cfg_frame_i`=1, while the request is released and no result is yet reached. Beats with any other frame index, and beats that arrive while `sync_no` is low, change neither the outputs nor the counter phase.
- R4: With `cfg_phadj_i`=1 and `cfg_adj_cnt_i`=N>0, the block applies N steps, at most one per period. Direction 0 (advance) shortens N periods to P-1 cycles each. Direction 1 (delay) lengthens N periods to P+1 cycles each. Afterwards the counter is ahead of its uncorrected value by (advances - delays) mod P.
- R5: After the last step of a correction, `sync_no` goes low again to make a new request.
- R6: A frame-1 beat with `cfg_phadj_i`=0 or `cfg_adj_cnt_i`=0 sets `aligned_o`. While `aligned_o` is high, `sync_no` stays high, the phase does not move, and `aligned_o` holds until reset.
- R7: After MAX_RETRY corrections, a further frame-1 beat that commands a nonzero correction sets `align_err_o` instead of starting a new correction. From then on `sync_no` stays high and no step is applied until reset.
- R8: `aligned_o` and `align_err_o` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cgs_ok_i | input | 1 | Lane reports code groups are being received |
| cfg_valid_i | input | 1 | Decoded configuration beat is valid |
| cfg_frame_i | input | $clog2(FRAMES_PER_MF) | Frame index of the beat within the configuration multiframe |
| cfg_phadj_i | input | 1 | Phase adjust requested |
| cfg_adj_cnt_i | input | ADJ_W | Number of one-cycle steps to apply |
| cfg_adj_dir_i | input | 1 | 0 advance, 1 delay |
| sync_no | output | 1 | Synchronization request, active low |
| lmfc_edge_o | output | 1 | Multiframe boundary pulse |
| aligned_o | output | 1 | Phase loop finished with zero residual |
| align_err_o | output | 1 | Retry limit exceeded |

## Verification
The bench builds the block with four frames per multiframe, four octets per frame and four octets per clock, which gives a period of 4 cycles. It also uses a 4-bit step count and a retry limit of 3. With these values every step count from 0 to 15 in both directions can be swept, each run starting from a fresh reset. The final phase and the number of shortened and lengthened periods are checked against arithmetic from the commanded counts. The short retry limit makes the error exit reachable after three loops, and the low `cgs_ok_i` case shows that the request is held beyond its minimum.

// File: rtl/lmfc_adj_pkg.sv
package lmfc_adj_pkg;
  typedef enum logic [2:0] {
    ST_REQ  = 3'd0,
    ST_WAIT = 3'd1,
    ST_ADJ  = 3'd2,
    ST_DONE = 3'd3,
    ST_FAIL = 3'd4
  } ctrl_state_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_SKIP = 2'd1,
    STEP_HOLD = 2'd2
  } step_e;
endpackage

// File: rtl/lmfc_counter.sv
module lmfc_counter
  import lmfc_adj_pkg::*;
#(
  parameter int unsigned PERIOD = 8,
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  step_e         step_i,
  output logic [CW-1:0] cnt_o,
  output logic          edge_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last = (cnt_q == CW'(PERIOD - 1));

  always_comb begin
    case (step_i)
      STEP_SKIP: cnt_d = '0;     // issued only at PERIOD-2
      STEP_HOLD: cnt_d = cnt_q;
      default:   cnt_d = last ? '0 : cnt_q + CW'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign edge_o = (cnt_q == '0);
endmodule

// File: rtl/lmfc_step_sched.sv
module lmfc_step_sched
  import lmfc_adj_pkg::*;
#(
  parameter int unsigned PERIOD = 8,
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          dir_i,
  input  logic [CW-1:0] cnt_i,
  output step_e         step_o
);
  logic held_q, skip_now, hold_now;

  // one step per period: skip at PERIOD-2, hold once at PERIOD-1
  assign skip_now = active_i && !dir_i && (cnt_i == CW'(PERIOD - 2));
  assign hold_now = active_i &&  dir_i && (cnt_i == CW'(PERIOD - 1)) && !held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= 1'b0;
    else         held_q <= hold_now;
  end

  always_comb begin
    if (skip_now)      step_o = STEP_SKIP;
    else if (hold_now) step_o = STEP_HOLD;
    else               step_o = STEP_NONE;
  end
endmodule

// File: rtl/lmfc_sync_hold.sv
module lmfc_sync_hold #(
  parameter int unsigned PERIOD = 8,
  localparam int unsigned HW = $clog2(PERIOD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic cgs_ok_i,
  output logic release_o
);
  logic [HW-1:0] hold_q;
  logic          min_met;

  assign min_met = (hold_q == HW'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hold_q <= '0;
    else if (!req_i)   hold_q <= '0;
    else if (!min_met) hold_q <= hold_q + HW'(1);
  end

  assign release_o = req_i && cgs_ok_i && min_met;
endmodule

// File: rtl/lmfc_adj_fsm.sv
module lmfc_adj_fsm
  import lmfc_adj_pkg::*;
#(
  parameter int unsigned ADJ_W     = 5,
  parameter int unsigned FIDX_W    = 4,
  parameter int unsigned CFG_FRAME = 1,
  parameter int unsigned MAX_RETRY = 4,
  localparam int unsigned RW = $clog2(MAX_RETRY + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic [FIDX_W-1:0] cfg_frame_i,
  input  logic              phadj_i,
  input  logic [ADJ_W-1:0]  adj_cnt_i,
  input  logic              adj_dir_i,
  input  logic              release_i,
  input  logic              step_taken_i,
  output ctrl_state_e       state_o,
  output logic              dir_o
);
  ctrl_state_e       st_q, st_d;
  logic [ADJ_W-1:0]  pend_q, pend_d;
  logic              dir_q, dir_d;
  logic [RW-1:0]     tries_q, tries_d;
  logic              cfg_hit;

  assign cfg_hit = cfg_valid_i && (cfg_frame_i == FIDX_W'(CFG_FRAME));

  always_comb begin
    st_d    = st_q;
    pend_d  = pend_q;
    dir_d   = dir_q;
    tries_d = tries_q;
    case (st_q)
      ST_REQ: if (release_i) st_d = ST_WAIT;
      ST_WAIT: if (cfg_hit) begin
        if (!phadj_i || adj_cnt_i == '0) begin
          st_d = ST_DONE;
        end else if (tries_q == RW'(MAX_RETRY)) begin
          st_d = ST_FAIL;
        end else begin
          st_d    = ST_ADJ;
          pend_d  = adj_cnt_i;
          dir_d   = adj_dir_i;
          tries_d = tries_q + RW'(1);
        end
      end
      ST_ADJ: if (step_taken_i) begin
        pend_d = pend_q - ADJ_W'(1);
        if (pend_q == ADJ_W'(1)) st_d = ST_REQ;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_REQ;
      pend_q  <= '0;
      dir_q   <= 1'b0;
      tries_q <= '0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      dir_q   <= dir_d;
      tries_q <= tries_d;
    end
  end

  assign state_o = st_q;
  assign dir_o   = dir_q;
endmodule

// File: rtl/lmfc_phase_ctrl.sv
module lmfc_phase_ctrl
  import lmfc_adj_pkg::*;
#(
  parameter int unsigned FRAMES_PER_MF    = 16,
  parameter int unsigned OCTETS_PER_FRAME = 2,
  parameter int unsigned OCTETS_PER_CLK   = 4,
  parameter int unsigned ADJ_W            = 5,
  parameter int unsigned MAX_RETRY        = 4,
  parameter int unsigned CFG_FRAME        = 1,
  localparam int unsigned PERIOD = FRAMES_PER_MF * OCTETS_PER_FRAME / OCTETS_PER_CLK,
  localparam int unsigned FIDX_W = $clog2(FRAMES_PER_MF),
  localparam int unsigned CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cgs_ok_i,
  input  logic              cfg_valid_i,
  input  logic [FIDX_W-1:0] cfg_frame_i,
  input  logic              cfg_phadj_i,
  input  logic [ADJ_W-1:0]  cfg_adj_cnt_i,
  input  logic              cfg_adj_dir_i,
  output logic              sync_no,
  output logic              lmfc_edge_o,
  output logic              aligned_o,
  output logic              align_err_o
);
  ctrl_state_e   state;
  step_e         step;
  logic [CW-1:0] cnt;
  logic          dir, rel;

  lmfc_counter #(.PERIOD(PERIOD)) i_cnt (
    .clk_i, .rst_ni, .step_i(step), .cnt_o(cnt), .edge_o(lmfc_edge_o)
  );

  lmfc_step_sched #(.PERIOD(PERIOD)) i_sched (
    .clk_i, .rst_ni, .active_i(state == ST_ADJ), .dir_i(dir),
    .cnt_i(cnt), .step_o(step)
  );

  lmfc_sync_hold #(.PERIOD(PERIOD)) i_hold (
    .clk_i, .rst_ni, .req_i(state == ST_REQ), .cgs_ok_i, .release_o(rel)
  );

  lmfc_adj_fsm #(
    .ADJ_W(ADJ_W), .FIDX_W(FIDX_W), .CFG_FRAME(CFG_FRAME), .MAX_RETRY(MAX_RETRY)
  ) i_fsm (
    .clk_i, .rst_ni, .cfg_valid_i, .cfg_frame_i,
    .phadj_i(cfg_phadj_i), .adj_cnt_i(cfg_adj_cnt_i), .adj_dir_i(cfg_adj_dir_i),
    .release_i(rel), .step_taken_i(step != STEP_NONE),
    .state_o(state), .dir_o(dir)
  );

  assign sync_no     = (state != ST_REQ);
  assign aligned_o   = (state == ST_DONE);
  assign align_err_o = (state == ST_FAIL);
endmodule

// File: rtl/lmfc_phase_ctrl_chk.sv
module lmfc_phase_ctrl_chk #(
  parameter int unsigned PERIOD = 8,
  localparam int unsigned GW = $clog2(PERIOD + 3)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sync_no,
  input logic lmfc_edge_o,
  input logic aligned_o,
  input logic align_err_o
);
  logic [GW-1:0] low_q, gap_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= '0;
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (sync_no)                      low_q <= '0;
      else if (low_q != GW'(PERIOD))    low_q <= low_q + GW'(1);
      if (lmfc_edge_o)                  gap_q <= GW'(1);
      else if (gap_q != GW'(PERIOD + 2)) gap_q <= gap_q + GW'(1);
      if (lmfc_edge_o) seen_q <= 1'b1;
    end
  end

  assert_min_request_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_no) |-> (low_q >= GW'(PERIOD)));

  assert_edge_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lmfc_edge_o && seen_q) |-> (gap_q >= GW'(PERIOD - 1) && gap_q <= GW'(PERIOD + 1)));

  assert_aligned_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aligned_o |=> (aligned_o && sync_no));

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |=> (align_err_o && sync_no));

  assert_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(aligned_o && align_err_o));
endmodule

bind lmfc_phase_ctrl lmfc_phase_ctrl_chk #(.PERIOD(PERIOD)) i_lmfc_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_no(sync_no), .lmfc_edge_o(lmfc_edge_o),
  .aligned_o(aligned_o), .align_err_o(align_err_o)
);

// File: tb/test_lmfc_phase_ctrl.sv
`timescale 1ns/100ps
module test_lmfc_phase_ctrl;
  localparam int K = 4, F = 4, OPC = 4, AW = 4, RETRY = 3;
  localparam int P = K * F / OPC;
  localparam int FW = $clog2(K);

  logic clk = 1'b0, rst_n = 1'b0, cgs_ok = 1'b1;
  logic cfg_valid = 1'b0, cfg_phadj = 1'b0, cfg_dir = 1'b0;
  logic [FW-1:0] cfg_frame = '0;
  logic [AW-1:0] cfg_cnt = '0;
  logic sync_n, edge_p, aligned, err;

  int checks = 0, fails = 0, k = 0, cyc = 0;
  int last_edge = 0, have_last = 0, shorts = 0, longs = 0, odd_gaps = 0, low_run = 0;

  always #2.5 clk = ~clk;

  lmfc_phase_ctrl #(
    .FRAMES_PER_MF(K), .OCTETS_PER_FRAME(F), .OCTETS_PER_CLK(OPC),
    .ADJ_W(AW), .MAX_RETRY(RETRY), .CFG_FRAME(1)
  ) i_lmfc_phase_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cgs_ok_i(cgs_ok), .cfg_valid_i(cfg_valid),
    .cfg_frame_i(cfg_frame), .cfg_phadj_i(cfg_phadj), .cfg_adj_cnt_i(cfg_cnt),
    .cfg_adj_dir_i(cfg_dir), .sync_no(sync_n), .lmfc_edge_o(edge_p),
    .aligned_o(aligned), .align_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (k=%0d)", req, act, exp, k);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst_n) k <= k + 1;
  end

  // monitor: boundary spacing and request length (R1, R2)
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (edge_p) begin
        if (have_last != 0) begin
          if (k - last_edge == P - 1)      shorts++;
          else if (k - last_edge == P + 1) longs++;
          else if (k - last_edge != P)     odd_gaps++;
        end
        have_last = 1;
        last_edge = k;
      end
      if (!sync_n) low_run++;
      else begin
        if (low_run > 0) chk(low_run >= P, "R2 min low", low_run, P);
        low_run = 0;
      end
    end
  end

  initial begin
    #700000;
    fails++;
    $display("FAIL watchdog: actual %0d expected 0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic do_reset(input logic cgs);
    @(negedge clk);
    rst_n = 1'b0;
    cgs_ok = cgs;
    cfg_valid = 1'b0;
    repeat (2) @(negedge clk);
    k = 0; have_last = 0; shorts = 0; longs = 0; odd_gaps = 0; low_run = 0;
    rst_n = 1'b1;
  endtask

  task automatic send_cfg(input int fr, input logic ph, input int n, input logic d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_frame = FW'(fr); cfg_phadj = ph; cfg_cnt = AW'(n); cfg_dir = d;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic wait_sync(input logic val, input int limit, input string req);
    int n = 0;
    while (sync_n !== val && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(sync_n === val, req, int'(sync_n), int'(val));
  endtask

  task automatic check_phase(input int bias, input string req);
    for (int i = 0; i < 2 * P; i++) begin
      @(negedge clk);
      chk(edge_p == (((k + 64 * P + bias) % P) == 0), req, int'(edge_p), int'(((k + 64 * P + bias) % P) == 0));
    end
  endtask

  initial begin
    // R1 R2: reset state
    do_reset(1'b1);
    chk(edge_p == 1'b1, "R1 edge at reset", int'(edge_p), 1);
    chk(sync_n == 1'b0, "R2 request at reset", int'(sync_n), 0);
    chk(aligned == 1'b0 && err == 1'b0, "R8 flags at reset", int'({aligned, err}), 0);

    // sweep every step count in both directions
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < (1 << AW); s++) begin
        do_reset(1'b1);
        wait_sync(1'b1, 4 * P, "R2 release");
        send_cfg(0, 1'b1, 3, 1'b0);           // R3: wrong frame index
        send_cfg(2, 1'b1, 5, 1'b1);
        repeat (P) @(negedge clk);
        chk(sync_n == 1'b1 && aligned == 1'b0, "R3 other frame ignored", int'({sync_n, aligned}), 2);
        send_cfg(1, 1'b1, s, d[0]);
        if (s > 0) begin
          wait_sync(1'b0, (s + 2) * (P + 1), "R5 new request");
          wait_sync(1'b1, 4 * P, "R2 release after adjust");
          send_cfg(1, 1'b1, 0, 1'b0);
        end
        chk(aligned == 1'b1 && err == 1'b0, "R6 aligned", int'({aligned, err}), 2);
        chk(shorts == (d == 0 ? s : 0), "R4 advance periods", shorts, d == 0 ? s : 0);
        chk(longs == (d == 1 ? s : 0), "R4 delay periods", longs, d == 1 ? s : 0);
        chk(odd_gaps == 0, "R1 spacing", odd_gaps, 0);
        check_phase(d == 0 ? s : -s, "R4 final phase");
        chk(sync_n == 1'b1 && aligned == 1'b1, "R6 hold aligned", int'({sync_n, aligned}), 3);
      end
    end

    // R2 R3 R6: request held while cgs_ok low; beats during request ignored
    do_reset(1'b0);
    send_cfg(1, 1'b0, 0, 1'b0);
    repeat (3 * P) @(negedge clk);
    chk(sync_n == 1'b0, "R2 held by cgs", int'(sync_n), 0);
    chk(aligned == 1'b0, "R3 beat during request", int'(aligned), 0);
    cgs_ok = 1'b1;
    wait_sync(1'b1, 2, "R2 release on cgs");
    chk(aligned == 1'b0, "R3 no late capture", int'(aligned), 0);
    send_cfg(1, 1'b0, 5, 1'b1);
    chk(aligned == 1'b1, "R6 phadj clear aligns", int'(aligned), 1);
    chk(shorts == 0 && longs == 0, "R6 no shift", shorts + longs, 0);
    check_phase(0, "R6 phase unchanged");

    // R7 R8: retry limit
    do_reset(1'b1);
    for (int r = 0; r < RETRY; r++) begin
      wait_sync(1'b1, 4 * P, "R2 release loop");
      send_cfg(1, 1'b1, 1, 1'b0);
      wait_sync(1'b0, 3 * P, "R5 loop request");
    end
    wait_sync(1'b1, 4 * P, "R2 release last");
    send_cfg(1, 1'b1, 1, 1'b0);
    chk(err == 1'b1 && aligned == 1'b0, "R7 error flag", int'({err, aligned}), 2);
    send_cfg(1, 1'b1, 0, 1'b0);
    repeat (3 * P) @(negedge clk);
    chk(err == 1'b1 && aligned == 1'b0, "R8 error sticky", int'({err, aligned}), 2);
    chk(sync_n == 1'b1, "R7 no request", int'(sync_n), 1);
    chk(shorts == RETRY && longs == 0, "R7 no step after error", shorts, RETRY);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule